// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor three 8-bit parallel ports, A, B and C. It sits behind a 2-bit register address and an 8-bit data bus. A control word sets, for group A (port A plus the upper half of port C) and group B (port B plus the lower half of port C), whether each port is a plain latched output, a plain unlatched input, or a strobed port with a handshake. In a strobed mode some port C lines stop carrying data and become strobe, acknowledge, buffer-status and interrupt lines. Port A also has a bidirectional strobed mode, in which both handshakes run on the same eight data lines.

The block drives no pads itself. Every port presents an output value and an output-enable. Port C has one enable per bit, so the pads can be tri-stated outside the block. All pin inputs are taken as synchronous to the clock. The external strobe and acknowledge lines are active low.

Top module: `pio_ctrl`

## Requirements
- R1: The register addresses are 0 = port A, 1 = port B, 2 = port C and 3 = control. Reading address 3 returns the last mode word written. After reset that word is 0xF4: every port is in mode 0 as an input, and every latch holds 0.
- R2: A write to address 3 with bit 7 = 1 is a mode word. Its fields are: bits 1:0 set the port A mode (0 simple, 1 strobed, 2 or 3 bidirectional); bit 2 = 1 makes port A an input; bit 3 = 1 makes port B strobed; bit 4 = 1 makes port B an input; bit 5 = 1 makes C[7:4] inputs; bit 6 = 1 makes C[3:0] inputs.
- R3: A mode word clears the port A, B and C output latches. It also clears every buffer flag and every interrupt enable.
- R4: A write to address 3 with bit 7 = 0 changes one port C latch bit. Bits 3:1 give the bit index and bit 0 gives the new value.
- R5: In mode 0, an output port drives its latch with the enable high, and a read returns the latch. An input port has its enable low, and a read returns the live pin value.
- R6: A port C bit that no handshake uses follows the direction of its half. As an output it drives its latch bit.
- R7: In strobed input, a falling edge on the port's strobe captures the pins and sets the input-full flag. Port A uses strobe C4 and flag C5; port B uses strobe C2 and flag C1; both flags read 1 when full. A read of the port returns the captured byte, even if the pins have since changed, and clears the flag.
- R8: In strobed output, a write to the port sets the output-full flag. Port A drives this flag on C7 and port B on C1, and the pin is 0 while the buffer is full. An acknowledge level of 0 (port A on C6, port B on C2) clears the flag.
- R9: Port A raises its interrupt on C3 and port B on C0. The enables are the port C latch bits C4 (A input), C6 (A output) and C2 (B). An interrupt is high when the port's input is full, or when its output has been acknowledged since the last write, and the matching enable is 1. A read of port C returns the enable at each strobe or acknowledge position and the flag values at the handshake outputs.
- R10: In mode 2, port A drives its pins only while acknowledge C6 is low. Strobe C4 captures input on the same lines. C3, C5 and C7 carry the interrupt and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Register access select |
| rd | input | 1 | Read cycle, one clock per access |
| wr | input | 1 | Write cycle, one clock per access |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-bit output enables |

## Verification
The bench changes port A's pins after a strobe and then reads port A. A design that passes the pins through instead of holding the captured byte returns the new value. It also checks that the read clears the full flag and the interrupt at the same moment, which catches a flag left stuck. In mode 2 the bench watches the port A enable follow the acknowledge line in both directions. A design that leaves port A driving during a strobe would fight the other device. It checks that a second mode word drops a full flag that is pending, and that a strobe with its enable cleared sets the flag but raises no interrupt. The bit-set writes are checked by setting a bit and then clearing it again.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] REG_A = 2'd0;
  localparam logic [AW-1:0] REG_B = 2'd1;
  localparam logic [AW-1:0] REG_C = 2'd2;
  localparam logic [AW-1:0] REG_CTRL = 2'd3;
  localparam logic [PW-1:0] CW_RESET = 8'hF4;

  typedef enum logic [1:0] {MODE_SIMPLE = 2'd0, MODE_STROBED = 2'd1, MODE_BIDIR = 2'd2} amode_e;

  typedef struct packed {
    amode_e a_mode;
    logic   a_in;
    logic   b_mode;
    logic   b_in;
    logic   ch_in;
    logic   cl_in;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [PW-1:0] w);
    cfg_t c;
    c.a_mode = (w[1:0] == 2'd0) ? MODE_SIMPLE : (w[1:0] == 2'd1) ? MODE_STROBED : MODE_BIDIR;
    c.a_in   = w[2];
    c.b_mode = w[3];
    c.b_in   = w[4];
    c.ch_in  = w[5];
    c.cl_in  = w[6];
    return c;
  endfunction

  // single-bit update of the port C latch: index in w[3:1], value in w[0]
  function automatic logic [PW-1:0] set_cbit(input logic [PW-1:0] cur, input logic [PW-1:0] w);
    logic [PW-1:0] r;
    r = cur;
    r[w[3:1]] = w[0];
    return r;
  endfunction
endpackage

// File: rtl/pio_in_latch.sv
module pio_in_latch import pio_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          active,
  input  logic          strobe_n,
  input  logic [PW-1:0] pins,
  input  logic          rd_hit,
  output logic          full,
  output logic [PW-1:0] data,
  output logic          capture
);
  logic strobe_q;

  assign capture = active & strobe_q & ~strobe_n & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      full     <= 1'b0;
      data     <= '0;
    end else begin
      strobe_q <= strobe_n;
      if (clear) full <= 1'b0;
      else if (capture) begin
        full <= 1'b1;
        data <= pins;
      end else if (rd_hit) full <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic wr_hit,
  input  logic ack_n,
  output logic full,
  output logic acked,
  output logic release_evt
);
  assign release_evt = active & full & ~ack_n & ~wr_hit & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      acked <= 1'b0;
    end else if (clear) begin
      full  <= 1'b0;
      acked <= 1'b0;
    end else if (active & wr_hit) begin
      full  <= 1'b1;
      acked <= 1'b0;
    end else if (release_evt) begin
      full  <= 1'b0;
      acked <= 1'b1;
    end
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl import pio_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  localparam int NP = 2;  // handshaking ports: index 0 = A, 1 = B
  localparam int HALF = PW / 2;

  logic [PW-1:0] cw, la, lb, lc;
  cfg_t cfg;
  logic bus_wr, bus_rd, mode_def;
  logic a_in_hs, a_out_hs;
  logic [NP-1:0] in_act, out_act, strb_n, ack_n, rd_hit, wr_hit;
  logic [NP-1:0] in_full, out_full, acked, cap, rel;
  logic [PW-1:0] in_pins [NP];
  logic [PW-1:0] in_data [NP];
  logic [PW-1:0] in_data_a;
  logic irq_a, irq_b;
  logic [PW-1:0] hs_own, hs_drv, hs_val, c_read;

  assign cfg      = decode_cfg(cw);
  assign bus_wr   = sel & wr;
  assign bus_rd   = sel & rd;
  assign mode_def = bus_wr && (addr == REG_CTRL) && wdata[PW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw <= CW_RESET;
      la <= '0;
      lb <= '0;
      lc <= '0;
    end else if (bus_wr) begin
      case (addr)
        REG_A: la <= wdata;
        REG_B: lb <= wdata;
        REG_C: lc <= wdata;
        default: begin
          if (wdata[PW-1]) begin
            cw <= wdata;
            la <= '0;
            lb <= '0;
            lc <= '0;
          end else begin
            lc <= set_cbit(lc, wdata);
          end
        end
      endcase
    end
  end

  assign a_in_hs  = (cfg.a_mode == MODE_STROBED && cfg.a_in) || cfg.a_mode == MODE_BIDIR;
  assign a_out_hs = (cfg.a_mode == MODE_STROBED && !cfg.a_in) || cfg.a_mode == MODE_BIDIR;
  assign in_act   = {cfg.b_mode & cfg.b_in, a_in_hs};
  assign out_act  = {cfg.b_mode & ~cfg.b_in, a_out_hs};
  assign strb_n   = {pc_in[2], pc_in[4]};
  assign ack_n    = {pc_in[2], pc_in[6]};
  assign rd_hit   = {bus_rd && addr == REG_B, bus_rd && addr == REG_A};
  assign wr_hit   = {bus_wr && addr == REG_B, bus_wr && addr == REG_A};
  assign in_pins[0] = pa_in;
  assign in_pins[1] = pb_in;
  assign in_data_a  = in_data[0];

  for (genvar p = 0; p < NP; p++) begin : g_hs
    pio_in_latch u_in (
      .clk(clk), .rst_n(rst_n), .clear(mode_def), .active(in_act[p]),
      .strobe_n(strb_n[p]), .pins(in_pins[p]), .rd_hit(rd_hit[p]),
      .full(in_full[p]), .data(in_data[p]), .capture(cap[p]));
    pio_out_latch u_out (
      .clk(clk), .rst_n(rst_n), .clear(mode_def), .active(out_act[p]),
      .wr_hit(wr_hit[p]), .ack_n(ack_n[p]),
      .full(out_full[p]), .acked(acked[p]), .release_evt(rel[p]));
  end

  assign irq_a = (in_full[0] & lc[4]) | (acked[0] & lc[6]);
  assign irq_b = (in_full[1] | acked[1]) & lc[2];

  always_comb begin
    hs_own = '0;
    hs_drv = '0;
    hs_val = '0;
    if (cfg.b_mode) begin
      hs_own[2:0] = 3'b111;
      hs_drv[1:0] = 2'b11;
      hs_val[0]   = irq_b;
      hs_val[1]   = cfg.b_in ? in_full[1] : ~out_full[1];
    end
    if (a_in_hs || a_out_hs) begin
      hs_own[3] = 1'b1;
      hs_drv[3] = 1'b1;
      hs_val[3] = irq_a;
    end
    if (a_in_hs) begin
      hs_own[5:4] = 2'b11;
      hs_drv[5]   = 1'b1;
      hs_val[5]   = in_full[0];
    end
    if (a_out_hs) begin
      hs_own[7:6] = 2'b11;
      hs_drv[7]   = 1'b1;
      hs_val[7]   = ~out_full[0];
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      logic gen_in;
      gen_in = (i >= HALF) ? cfg.ch_in : cfg.cl_in;
      if (hs_own[i]) begin
        pc_oe[i]  = hs_drv[i];
        pc_out[i] = hs_drv[i] ? hs_val[i] : lc[i];
        c_read[i] = hs_drv[i] ? hs_val[i] : lc[i];
      end else begin
        pc_oe[i]  = ~gen_in;
        pc_out[i] = lc[i];
        c_read[i] = gen_in ? pc_in[i] : lc[i];
      end
    end
  end

  assign pa_out = la;
  assign pb_out = lb;
  assign pa_oe  = (cfg.a_mode == MODE_BIDIR) ? ~pc_in[6] : ~cfg.a_in;
  assign pb_oe  = ~cfg.b_in;

  always_comb begin
    case (addr)
      REG_A:   rdata = a_in_hs ? in_data[0] : (cfg.a_in ? pa_in : la);
      REG_B:   rdata = in_act[1] ? in_data[1] : (cfg.b_in ? pb_in : lb);
      REG_C:   rdata = c_read;
      default: rdata = cw;
    endcase
  end
endmodule

// File: rtl/pio_ctrl_checks.sv
module pio_ctrl_checks import pio_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [PW-1:0] wdata,
  input logic          mode_def,
  input logic [1:0]    cap,
  input logic [1:0]    rel,
  input logic [1:0]    in_full,
  input logic [1:0]    out_full,
  input logic [1:0]    acked,
  input logic [1:0]    out_act,
  input logic [PW-1:0] in_data_a,
  input logic [PW-1:0] pa_in,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pc_out
);
  assert_mode_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_def |=> (pa_out == '0 && pb_out == '0 && in_full == '0 && out_full == '0 && acked == '0));

  assert_latch_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == REG_A) |=> pa_out == $past(wdata));

  assert_capture_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] |=> in_full[0]);

  assert_capture_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] |=> in_data_a == $past(pa_in));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && addr == REG_A && in_full[0] && !cap[0]) |=> !in_full[0]);

  assert_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == REG_B && out_act[1]) |=> out_full[1]);

  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel[1] |=> (!out_full[1] && acked[1]));

  assert_flag_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_def && wdata[3] && !wdata[4]) |=> pc_out[1]);
endmodule

bind pio_ctrl pio_ctrl_checks u_checks (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .mode_def(mode_def), .cap(cap), .rel(rel), .in_full(in_full), .out_full(out_full),
  .acked(acked), .out_act(out_act), .in_data_a(in_data_a), .pa_in(pa_in),
  .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out));

// File: tb/pio_ctrl_test.sv
module pio_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pb_out, pc_out, pc_oe;
  logic pa_oe, pb_oe;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe));

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
    #1;
  endtask

  task automatic pulse_c(input int bit_idx);
    @(negedge clk);
    pc_in[bit_idx] = 1'b0;
    @(negedge clk);
    pc_in[bit_idx] = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_read(2'd3, d);
    check8("R1 reset control word", d, 8'hF4);
    check8("R2 reset port enables", {6'b0, pa_oe, pb_oe}, 8'h00);
    check8("R2 reset port C enables", pc_oe, 8'h00);
  endtask

  task automatic t_mode0;
    logic [7:0] d;
    bus_write(2'd3, 8'h80);
    check8("R5 outputs enabled", {6'b0, pa_oe, pb_oe}, 8'h03);
    check8("R6 port C all outputs", pc_oe, 8'hFF);
    bus_write(2'd0, 8'h5A);
    check8("R5 port A drive", pa_out, 8'h5A);
    bus_read(2'd0, d);
    check8("R5 port A latch read", d, 8'h5A);
    bus_write(2'd2, 8'h3C);
    check8("R6 port C drive", pc_out, 8'h3C);
    bus_write(2'd3, 8'h03);
    check8("R4 set C1", pc_out, 8'h3E);
    bus_write(2'd3, 8'h0A);
    check8("R4 clear C5", pc_out, 8'h1E);
    bus_write(2'd3, 8'h84);
    check8("R3 latches cleared", pc_out | pa_out, 8'h00);
    check8("R5 port A input enable", {7'b0, pa_oe}, 8'h00);
    pa_in = 8'hC3;
    bus_read(2'd0, d);
    check8("R5 live pin read", d, 8'hC3);
    pa_in = 8'h18;
    bus_read(2'd0, d);
    check8("R5 live pin read 2", d, 8'h18);
  endtask

  task automatic t_strobed_in;
    logic [7:0] d;
    bus_write(2'd3, 8'h85);
    check8("R6 port C enables strobed in", pc_oe, 8'hEF);
    bus_write(2'd3, 8'h09);
    pa_in = 8'h77;
    pulse_c(4);
    check8("R7 full flag and R9 irq", {6'b0, pc_out[5], pc_out[3]}, 8'h03);
    pa_in = 8'h11;
    bus_read(2'd0, d);
    check8("R7 captured byte held", d, 8'h77);
    check8("R7 full cleared by read", {6'b0, pc_out[5], pc_out[3]}, 8'h00);
    bus_read(2'd2, d);
    check8("R9 port C status read", d, 8'h10);
    bus_write(2'd2, 8'hC0);
    check8("R6 spare C bits drive", pc_out & 8'hC0, 8'hC0);
    pulse_c(4);
    check8("R9 no irq when disabled", {6'b0, pc_out[5], pc_out[3]}, 8'h02);
  endtask

  task automatic t_strobed_out_b;
    bus_write(2'd3, 8'h88);
    bus_write(2'd3, 8'h05);
    check8("R8 idle not full", {7'b0, pc_out[1]}, 8'h01);
    bus_write(2'd1, 8'h9C);
    check8("R8 port B drive", pb_out, 8'h9C);
    check8("R8 full low, R9 no irq", {6'b0, pc_out[1], pc_out[0]}, 8'h00);
    pulse_c(2);
    check8("R8 ack releases, R9 irq", {6'b0, pc_out[1], pc_out[0]}, 8'h03);
    bus_write(2'd1, 8'h21);
    check8("R9 write drops irq", {6'b0, pc_out[1], pc_out[0]}, 8'h00);
  endtask

  task automatic t_bidir;
    logic [7:0] d;
    bus_write(2'd3, 8'h82);
    check8("R10 idle not driving", {7'b0, pa_oe}, 8'h00);
    bus_write(2'd0, 8'hE1);
    check8("R10 output full", {7'b0, pc_out[7]}, 8'h00);
    check8("R10 still not driving", {7'b0, pa_oe}, 8'h00);
    @(negedge clk);
    pc_in[6] = 1'b0;
    #1;
    check8("R10 drive during ack", {pa_oe, 7'b0} | (pa_out & 8'h7F), 8'hE1);
    @(negedge clk);
    pc_in[6] = 1'b1;
    #1;
    check8("R10 released after ack", {6'b0, pa_oe, pc_out[7]}, 8'h01);
    pa_in = 8'h42;
    pulse_c(4);
    check8("R10 input full", {7'b0, pc_out[5]}, 8'h01);
    bus_write(2'd3, 8'h82);
    check8("R3 mode word drops full", {7'b0, pc_out[5]}, 8'h00);
    pa_in = 8'h6B;
    pulse_c(4);
    pa_in = 8'h00;
    bus_read(2'd0, d);
    check8("R10 captured input", d, 8'h6B);
  endtask

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode0();
    t_strobed_in();
    t_strobed_out_b();
    t_bidir();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule